// File: doc/BRIEF.md
# Reversible Decade Counter

This block is a synchronous BCD counter that steps through the values 0 to 9 in either direction. A direction select picks the direction. Two separate next-state paths each compute one successor of the present count: one for counting up and one for counting down. A 2:1 multiplexer driven by the direction select passes one of them to the state register. Three active-low controls act on the rising clock edge: clear, parallel load and hold. A combinational terminal-count flag tells a neighbouring stage that the next counting edge will wrap.

The counter drives a single decade digit. Loaded values are sanitised so that the register never holds a code outside 0 to 9. The asynchronous reset puts the count at zero.

Top module: `dec_updown_counter`

## Requirements
- R1: While rst_ni is 0, count_o is 0, regardless of the other inputs.
- R2: With clr_ni, load_ni and hold_ni all 1 and dir_i = 0, each rising edge increments count_o by one. A count of 9 becomes 0.
- R3: With clr_ni, load_ni and hold_ni all 1 and dir_i = 1, each rising edge decrements count_o by one. A count of 0 becomes 9.
- R4: When clr_ni is 0 at a rising edge, count_o becomes 0. This takes priority over load, hold and counting.
- R5: When clr_ni is 1 and load_ni is 0 at a rising edge, count_o takes the value of load_val_i. This takes priority over hold and counting.
- R6: If a load presents a load_val_i of 10 to 15, count_o becomes 0 instead.
- R7: When clr_ni and load_ni are 1 and hold_ni is 0 at a rising edge, count_o keeps its value, and dir_i has no effect on it.
- R8: tc_o is combinational. It is 1 when dir_i = 0 and count_o = 9, or when dir_i = 1 and count_o = 0. It is 0 otherwise.
- R9: count_o never holds a value above 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; the state updates on the rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dir_i | input | 1 | Direction: 0 counts up, 1 counts down |
| clr_ni | input | 1 | Synchronous clear, active low |
| hold_ni | input | 1 | Synchronous hold, active low |
| load_ni | input | 1 | Synchronous parallel load, active low |
| load_val_i | input | 4 | BCD preset value used by a load |
| count_o | output | 4 | Present BCD count |
| tc_o | output | 1 | Terminal count (carry when counting up, borrow when counting down) |

## Verification
Each register update appears on count_o at the first rising edge after the controls are set up, with no added latency. The bench therefore drives inputs between edges and compares count_o one time unit after that edge against a model step it computes itself. tc_o depends only on the present count and dir_i, so it is checked before the edge in the same cycle its inputs settle. The hold and direction-toggle cases are checked over several edges to show that count_o does not move.

// File: rtl/dec_pkg.sv
package dec_pkg;
  localparam int unsigned DEC_W   = 4;
  localparam int unsigned DEC_MOD = 10;

  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } dir_e;
endpackage

// File: rtl/dec_up_next.sv
module dec_up_next #(
  parameter int unsigned W       = 4,
  parameter int unsigned MODULUS = 10
) (
  input  logic [W-1:0] cur_i,
  output logic [W-1:0] nxt_o
);
  localparam logic [W-1:0] TOP = W'(MODULUS - 1);

  always_comb begin
    if (cur_i >= TOP) nxt_o = '0;
    else              nxt_o = cur_i + W'(1);
  end
endmodule

// File: rtl/dec_down_next.sv
module dec_down_next #(
  parameter int unsigned W       = 4,
  parameter int unsigned MODULUS = 10
) (
  input  logic [W-1:0] cur_i,
  output logic [W-1:0] nxt_o
);
  localparam logic [W-1:0] TOP = W'(MODULUS - 1);

  always_comb begin
    if (cur_i == '0 || cur_i > TOP) nxt_o = TOP;
    else                            nxt_o = cur_i - W'(1);
  end
endmodule

// File: rtl/dec_dir_mux.sv
module dec_dir_mux #(
  parameter int unsigned W = 4
) (
  input  logic         sel_i,
  input  logic [W-1:0] up_i,
  input  logic [W-1:0] down_i,
  output logic [W-1:0] out_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    assign out_o[b] = sel_i ? down_i[b] : up_i[b];
  end
endmodule

// File: rtl/dec_updown_counter.sv
module dec_updown_counter
  import dec_pkg::*;
#(
  parameter int unsigned W       = DEC_W,
  parameter int unsigned MODULUS = DEC_MOD
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         dir_i,
  input  logic         clr_ni,
  input  logic         hold_ni,
  input  logic         load_ni,
  input  logic [W-1:0] load_val_i,
  output logic [W-1:0] count_o,
  output logic         tc_o
);
  localparam logic [W-1:0] TOP = W'(MODULUS - 1);

  logic [W-1:0] cnt_q, cnt_d;
  logic [W-1:0] up_nxt, down_nxt, step_nxt;
  logic [W-1:0] load_safe;

  dec_up_next #(.W(W), .MODULUS(MODULUS)) u_up (
    .cur_i (cnt_q),
    .nxt_o (up_nxt)
  );

  dec_down_next #(.W(W), .MODULUS(MODULUS)) u_down (
    .cur_i (cnt_q),
    .nxt_o (down_nxt)
  );

  dec_dir_mux #(.W(W)) u_mux (
    .sel_i  (dir_i),
    .up_i   (up_nxt),
    .down_i (down_nxt),
    .out_o  (step_nxt)
  );

  // out-of-range presets collapse to zero
  assign load_safe = (load_val_i > TOP) ? '0 : load_val_i;

  always_comb begin
    if (!clr_ni)       cnt_d = '0;
    else if (!load_ni) cnt_d = load_safe;
    else if (!hold_ni) cnt_d = cnt_q;
    else               cnt_d = step_nxt;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;
  assign tc_o    = (dir_i == DIR_DOWN) ? (cnt_q == '0) : (cnt_q == TOP);

  assert_in_range_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= TOP);

  assert_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_ni |=> count_o == '0);

  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_ni && load_ni && !hold_ni) |=> $stable(count_o));

  assert_up_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_ni && load_ni && hold_ni && !dir_i && count_o != TOP)
      |=> count_o == $past(count_o) + W'(1));

  assert_up_wrap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_ni && load_ni && hold_ni && !dir_i && count_o == TOP) |=> count_o == '0);

  assert_down_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_ni && load_ni && hold_ni && dir_i && count_o == '0) |=> count_o == TOP);

  assert_load_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_ni && !load_ni && load_val_i <= TOP) |=> count_o == $past(load_val_i));

  assert_reset_R1: assert property (@(posedge clk_i)
    !rst_ni |-> count_o == '0);
endmodule

// File: tb/sim_dec_updown_counter.sv
module sim_dec_updown_counter;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       dir_i = 1'b0;
  logic       clr_ni = 1'b1;
  logic       hold_ni = 1'b1;
  logic       load_ni = 1'b1;
  logic [3:0] load_val_i = 4'd0;
  logic [3:0] count_o;
  logic       tc_o;

  int n_chk = 0;
  int n_bad = 0;
  int exp_cnt = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  dec_updown_counter u0 (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .dir_i      (dir_i),
    .clr_ni     (clr_ni),
    .hold_ni    (hold_ni),
    .load_ni    (load_ni),
    .load_val_i (load_val_i),
    .count_o    (count_o),
    .tc_o       (tc_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    #1;
  endtask

  task automatic idle_ctrl();
    clr_ni = 1'b1; load_ni = 1'b1; hold_ni = 1'b1;
  endtask

  task automatic t_reset();
    rst_ni = 1'b0; dir_i = 1'b0; load_ni = 1'b0; load_val_i = 4'd5;
    step(); step();
    chk("R1 count in reset", count_o, 0);
    chk("R8 tc up at 0", tc_o, 0);
    dir_i = 1'b1; #1;
    chk("R8 tc down at 0", tc_o, 1);
    idle_ctrl(); dir_i = 1'b0;
    rst_ni = 1'b1;
    exp_cnt = 0;
    #1;
  endtask

  task automatic t_count_up();
    idle_ctrl(); dir_i = 1'b0; #1;
    for (int i = 0; i < 13; i++) begin
      chk("R8 tc while counting up", tc_o, (exp_cnt == 9) ? 1 : 0);
      step();
      exp_cnt = (exp_cnt == 9) ? 0 : exp_cnt + 1;
      chk("R2 up count", count_o, exp_cnt);
      chk("R9 range", (count_o <= 9) ? 1 : 0, 1);
    end
  endtask

  task automatic t_count_down();
    idle_ctrl(); dir_i = 1'b1; #1;
    for (int i = 0; i < 13; i++) begin
      chk("R8 tc while counting down", tc_o, (exp_cnt == 0) ? 1 : 0);
      step();
      exp_cnt = (exp_cnt == 0) ? 9 : exp_cnt - 1;
      chk("R3 down count", count_o, exp_cnt);
    end
  endtask

  task automatic t_load();
    idle_ctrl(); hold_ni = 1'b0; load_ni = 1'b0; load_val_i = 4'd7; dir_i = 1'b0;
    step(); exp_cnt = 7;
    chk("R5 load over hold", count_o, 7);
    load_val_i = 4'd9;
    step(); exp_cnt = 9;
    chk("R5 load 9", count_o, 9);
    idle_ctrl(); #1;
    chk("R8 tc up at 9", tc_o, 1);
  endtask

  task automatic t_load_bad();
    idle_ctrl(); load_ni = 1'b0; load_val_i = 4'd5;
    step();
    chk("R5 load 5", count_o, 5);
    load_val_i = 4'd12;
    step();
    chk("R6 load 12 gives 0", count_o, 0);
    load_val_i = 4'd3;
    step();
    load_val_i = 4'd15;
    step(); exp_cnt = 0;
    chk("R6 load 15 gives 0", count_o, 0);
    chk("R9 range after bad load", (count_o <= 9) ? 1 : 0, 1);
    idle_ctrl();
  endtask

  task automatic t_hold();
    idle_ctrl(); load_ni = 1'b0; load_val_i = 4'd4;
    step(); exp_cnt = 4;
    idle_ctrl(); hold_ni = 1'b0;
    for (int i = 0; i < 4; i++) begin
      dir_i = i[0];
      step();
      chk("R7 hold keeps count", count_o, 4);
    end
    dir_i = 1'b0; #1;
    chk("R8 tc low mid-range", tc_o, 0);
    idle_ctrl();
  endtask

  task automatic t_clear();
    idle_ctrl(); load_ni = 1'b0; load_val_i = 4'd6;
    step();
    clr_ni = 1'b0; load_ni = 1'b0; hold_ni = 1'b0; load_val_i = 4'd8; dir_i = 1'b1;
    step(); exp_cnt = 0;
    chk("R4 clear over load and hold", count_o, 0);
    idle_ctrl(); dir_i = 1'b1;
    step(); exp_cnt = 9;
    chk("R3 wrap after clear", count_o, 9);
    clr_ni = 1'b0; dir_i = 1'b0;
    step(); exp_cnt = 0;
    chk("R4 clear while counting", count_o, 0);
    idle_ctrl();
  endtask

  task automatic t_async_reset();
    idle_ctrl(); load_ni = 1'b0; load_val_i = 4'd8;
    step();
    idle_ctrl();
    #0.5 rst_ni = 1'b0; #0.5;
    chk("R1 asynchronous reset", count_o, 0);
    step();
    rst_ni = 1'b1; exp_cnt = 0;
  endtask

  initial begin
    t_reset();
    t_count_up();
    t_count_down();
    t_load();
    t_load_bad();
    t_hold();
    t_clear();
    t_async_reset();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule